// File: doc/BRIEF.md
# Translation Invalidation Command Decoder

This block takes fixed-format commands, one at a time, from a command queue through a valid/ready handshake. It turns each command into one-cycle invalidation strobes. Configuration invalidations arrive as a per-stream flush vector for a configuration cache, with one bit per stream ID. Translation invalidations arrive as an invalidate-all, invalidate-by-ASID or invalidate-by-ASID-and-address strobe for a translation cache, and the ASID and address are carried alongside the strobe.

A synchronisation command can raise an interrupt pulse. Prefetch commands are taken and dropped without any action. Several translation commands are deliberately folded onto a broader action: both invalidate-all forms and the address-across-all-ASIDs form each flush the whole translation cache. A configuration invalidation that carries the secure flag is rejected, and so is any opcode the block does not know. On a rejected command the block latches an illegal-command code and stops taking commands until reset.

The command word is laid out from bit 0 upward as follows:
- opcode [7:0]
- secure flag [8]
- sync completion mode [10:9]
- range exponent [15:11]
- stream ID, SID_W bits
- ASID, ASID_W bits
- address, ADDR_W bits

Top module: `inv_cmd_decoder`

## Requirements
- R1: After reset every strobe, err_code and halted are 0 and cmd_ready is 1. A command is consumed on a clock edge where cmd_valid and cmd_ready are both high. Its strobes appear on the next cycle for exactly one cycle, and at most one translation strobe is high at a time.
- R2: Opcodes 0x03, 0x05 and 0x06 with the secure flag clear set only the cfg_flush bit of the given stream ID, and only if stream_attached holds that ID. For a detached ID they set no bit.
- R3: Opcode 0x04 with the secure flag clear sets cfg_flush for each attached ID from start to start + 2^(range+1) − 1. IDs past the last stream are dropped.
- R4: Opcodes 0x03 to 0x06 with bit 8 set produce err_code 1 and no cfg_flush bit.
- R5: Opcodes 0x10 and 0x30 pulse tlb_inv_all.
- R6: Opcode 0x11 pulses tlb_inv_asid, with tlb_asid equal to the command's ASID.
- R7: Opcode 0x13 pulses tlb_inv_all.
- R8: Opcode 0x12 pulses tlb_inv_va, with tlb_asid and tlb_addr equal to the command's fields.
- R9: Opcodes 0x01 and 0x02 are consumed with no strobe and no error.
- R10: Opcode 0x46 pulses sync_irq when bits [10:9] equal 2'b01. With any other mode it does nothing.
- R11: Any other opcode produces err_code 1.
- R12: After an error, halted is 1, cmd_ready is 0, err_code holds its value and no strobe fires until reset.
- R13: The secure flag has no effect on translation and sync commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_word | input | 16+SID_W+ASID_W+ADDR_W | Command word |
| stream_attached | input | 2^SID_W | One bit per stream ID that has a device |
| cfg_flush | output | 2^SID_W | Per-stream configuration flush pulse |
| tlb_inv_all | output | 1 | Flush the whole translation cache |
| tlb_inv_asid | output | 1 | Flush entries of tlb_asid |
| tlb_inv_va | output | 1 | Flush the tlb_asid/tlb_addr entry |
| tlb_asid | output | ASID_W | ASID for the translation strobes |
| tlb_addr | output | ADDR_W | Address for tlb_inv_va |
| sync_irq | output | 1 | Sync completion interrupt pulse |
| err_code | output | 2 | 0 none, 1 illegal command |
| halted | output | 1 | Processing stopped on an error |

## Verification
The table sends every supported opcode at least once. Each case is built to tell folded actions apart from narrow ones, for example address-across-all-ASIDs against address-with-ASID. Stream invalidations use attached and detached IDs, a range inside the ID space, a range that runs past the last ID, and a range covering the whole space. The range cases separate the end-point arithmetic from clipping. Error cases use a secure configuration command and an unknown opcode, each followed by a pending command. These show that the block halts and that the pending command is not consumed.

// File: rtl/inv_pkg.sv
package inv_pkg;

  localparam int OP_W  = 8;
  localparam int ERR_W = 2;

  localparam logic [OP_W-1:0] OP_PREF_CFG   = 8'h01;
  localparam logic [OP_W-1:0] OP_PREF_ADDR  = 8'h02;
  localparam logic [OP_W-1:0] OP_CFG_STREAM = 8'h03;
  localparam logic [OP_W-1:0] OP_CFG_RANGE  = 8'h04;
  localparam logic [OP_W-1:0] OP_CFG_CTX    = 8'h05;
  localparam logic [OP_W-1:0] OP_CFG_CTXALL = 8'h06;
  localparam logic [OP_W-1:0] OP_TLB_ALL    = 8'h10;
  localparam logic [OP_W-1:0] OP_TLB_ASID   = 8'h11;
  localparam logic [OP_W-1:0] OP_TLB_VA     = 8'h12;
  localparam logic [OP_W-1:0] OP_TLB_VAA    = 8'h13;
  localparam logic [OP_W-1:0] OP_TLB_GALL   = 8'h30;
  localparam logic [OP_W-1:0] OP_SYNC       = 8'h46;

  localparam logic [1:0] SYNC_MODE_IRQ = 2'b01;

  localparam logic [ERR_W-1:0] ERR_NONE    = 2'd0;
  localparam logic [ERR_W-1:0] ERR_ILLEGAL = 2'd1;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_CFG_ONE,
    ACT_CFG_RANGE,
    ACT_TLB_ALL,
    ACT_TLB_ASID,
    ACT_TLB_VA,
    ACT_SYNC,
    ACT_ILLEGAL
  } act_e;

  function automatic logic is_cfg_op(input logic [OP_W-1:0] op);
    return (op == OP_CFG_STREAM) || (op == OP_CFG_RANGE) ||
           (op == OP_CFG_CTX) || (op == OP_CFG_CTXALL);
  endfunction

endpackage

// File: rtl/inv_cmd_classify.sv
module inv_cmd_classify
  import inv_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            secure,
  input  logic [1:0]      sync_mode,
  output act_e            act,
  output logic            irq
);

  always_comb begin
    act = ACT_ILLEGAL;
    irq = 1'b0;
    case (op)
      OP_PREF_CFG, OP_PREF_ADDR:              act = ACT_NONE;
      OP_CFG_STREAM, OP_CFG_CTX, OP_CFG_CTXALL: act = secure ? ACT_ILLEGAL : ACT_CFG_ONE;
      OP_CFG_RANGE:                           act = secure ? ACT_ILLEGAL : ACT_CFG_RANGE;
      OP_TLB_ALL, OP_TLB_GALL, OP_TLB_VAA:    act = ACT_TLB_ALL;
      OP_TLB_ASID:                            act = ACT_TLB_ASID;
      OP_TLB_VA:                              act = ACT_TLB_VA;
      OP_SYNC: begin
        act = ACT_SYNC;
        irq = (sync_mode == SYNC_MODE_IRQ);
      end
      default:                                act = ACT_ILLEGAL;
    endcase
  end

endmodule

// File: rtl/inv_stream_select.sv
module inv_stream_select #(
  parameter int SID_W   = 8,
  parameter int RANGE_W = 5
) (
  input  logic [SID_W-1:0]        start,
  input  logic [RANGE_W-1:0]      range_exp,
  input  logic                    use_range,
  input  logic [(1<<SID_W)-1:0]   attached,
  output logic [(1<<SID_W)-1:0]   mask
);

  localparam int NUM_STREAMS = 1 << SID_W;
  localparam int EXT_W       = (1 << RANGE_W) + SID_W + 2;

  logic [EXT_W-1:0]   start_ext;
  logic [RANGE_W:0]   shift_amt;
  logic [EXT_W-1:0]   last_ext;

  always_comb begin
    start_ext = EXT_W'(start);
    shift_amt = {1'b0, range_exp} + 1'b1;
    last_ext  = start_ext + (EXT_W'(1) << shift_amt) - EXT_W'(1);
  end

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_sid
    localparam logic [EXT_W-1:0] IDX_EXT = EXT_W'(i);
    localparam logic [SID_W-1:0] IDX     = SID_W'(i);
    logic hit;
    always_comb begin
      if (use_range) hit = (IDX_EXT >= start_ext) && (IDX_EXT <= last_ext);
      else           hit = (start == IDX);
      mask[i] = hit && attached[i];
    end
  end

endmodule

// File: rtl/inv_cmd_decoder.sv
module inv_cmd_decoder
  import inv_pkg::*;
#(
  parameter int SID_W   = 8,
  parameter int ASID_W  = 16,
  parameter int ADDR_W  = 32,
  parameter int RANGE_W = 5
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  cmd_valid,
  output logic                                  cmd_ready,
  input  logic [11+RANGE_W+SID_W+ASID_W+ADDR_W-1:0] cmd_word,
  input  logic [(1<<SID_W)-1:0]                 stream_attached,
  output logic [(1<<SID_W)-1:0]                 cfg_flush,
  output logic                                  tlb_inv_all,
  output logic                                  tlb_inv_asid,
  output logic                                  tlb_inv_va,
  output logic [ASID_W-1:0]                     tlb_asid,
  output logic [ADDR_W-1:0]                     tlb_addr,
  output logic                                  sync_irq,
  output logic [ERR_W-1:0]                      err_code,
  output logic                                  halted
);

  localparam int NUM_STREAMS = 1 << SID_W;
  localparam int SEC_POS     = OP_W;
  localparam int MODE_POS    = SEC_POS + 1;
  localparam int RANGE_POS   = MODE_POS + 2;
  localparam int SID_POS     = RANGE_POS + RANGE_W;
  localparam int ASID_POS    = SID_POS + SID_W;
  localparam int ADDR_POS    = ASID_POS + ASID_W;

  logic [OP_W-1:0]        f_op;
  logic                   f_sec;
  logic [1:0]             f_mode;
  logic [RANGE_W-1:0]     f_range;
  logic [SID_W-1:0]       f_sid;
  logic [ASID_W-1:0]      f_asid;
  logic [ADDR_W-1:0]      f_addr;

  assign f_op    = cmd_word[OP_W-1:0];
  assign f_sec   = cmd_word[SEC_POS];
  assign f_mode  = cmd_word[MODE_POS +: 2];
  assign f_range = cmd_word[RANGE_POS +: RANGE_W];
  assign f_sid   = cmd_word[SID_POS +: SID_W];
  assign f_asid  = cmd_word[ASID_POS +: ASID_W];
  assign f_addr  = cmd_word[ADDR_POS +: ADDR_W];

  act_e                   act;
  logic                   act_irq;
  logic [NUM_STREAMS-1:0] sel_mask;
  logic                   take;

  inv_cmd_classify u_classify (
    .op        (f_op),
    .secure    (f_sec),
    .sync_mode (f_mode),
    .act       (act),
    .irq       (act_irq)
  );

  inv_stream_select #(
    .SID_W   (SID_W),
    .RANGE_W (RANGE_W)
  ) u_select (
    .start     (f_sid),
    .range_exp (f_range),
    .use_range (act == ACT_CFG_RANGE),
    .attached  (stream_attached),
    .mask      (sel_mask)
  );

  assign cmd_ready = !halted;
  assign take      = cmd_valid && !halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_flush    <= '0;
      tlb_inv_all  <= 1'b0;
      tlb_inv_asid <= 1'b0;
      tlb_inv_va   <= 1'b0;
      tlb_asid     <= '0;
      tlb_addr     <= '0;
      sync_irq     <= 1'b0;
      err_code     <= ERR_NONE;
      halted       <= 1'b0;
    end else begin
      cfg_flush    <= '0;
      tlb_inv_all  <= 1'b0;
      tlb_inv_asid <= 1'b0;
      tlb_inv_va   <= 1'b0;
      tlb_asid     <= '0;
      tlb_addr     <= '0;
      sync_irq     <= 1'b0;
      if (take) begin
        case (act)
          ACT_CFG_ONE, ACT_CFG_RANGE: cfg_flush <= sel_mask;
          ACT_TLB_ALL:  tlb_inv_all <= 1'b1;
          ACT_TLB_ASID: begin
            tlb_inv_asid <= 1'b1;
            tlb_asid     <= f_asid;
          end
          ACT_TLB_VA: begin
            tlb_inv_va <= 1'b1;
            tlb_asid   <= f_asid;
            tlb_addr   <= f_addr;
          end
          ACT_SYNC:     sync_irq <= act_irq;
          ACT_ILLEGAL: begin
            err_code <= ERR_ILLEGAL;
            halted   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/inv_cmd_decoder_chk.sv
module inv_cmd_decoder_chk
  import inv_pkg::*;
#(
  parameter int SID_W   = 8,
  parameter int ASID_W  = 16,
  parameter int ADDR_W  = 32,
  parameter int RANGE_W = 5
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic                                  cmd_valid,
  input logic                                  cmd_ready,
  input logic [11+RANGE_W+SID_W+ASID_W+ADDR_W-1:0] cmd_word,
  input logic [(1<<SID_W)-1:0]                 stream_attached,
  input logic [(1<<SID_W)-1:0]                 cfg_flush,
  input logic                                  tlb_inv_all,
  input logic                                  tlb_inv_asid,
  input logic                                  tlb_inv_va,
  input logic                                  sync_irq,
  input logic [ERR_W-1:0]                      err_code,
  input logic                                  halted
);

  logic            acc;
  logic [OP_W-1:0] op;
  logic            any_strobe;

  assign acc        = cmd_valid && cmd_ready;
  assign op         = cmd_word[OP_W-1:0];
  assign any_strobe = (|cfg_flush) || tlb_inv_all || tlb_inv_asid || tlb_inv_va || sync_irq;

  AST_TLB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tlb_inv_all, tlb_inv_asid, tlb_inv_va})); // R1

  AST_FLUSH_ATTACHED: assert property (@(posedge clk) disable iff (rst)
    (cfg_flush & ~$past(stream_attached)) == '0); // R2

  AST_SECURE_CFG_REJECT: assert property (@(posedge clk) disable iff (rst)
    acc && cmd_word[OP_W] && is_cfg_op(op) |=> (err_code == ERR_ILLEGAL) && (cfg_flush == '0)); // R4

  AST_PREFETCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    acc && (op == OP_PREF_CFG || op == OP_PREF_ADDR) |=> !any_strobe && !halted); // R9

  AST_IRQ_FROM_SYNC: assert property (@(posedge clk) disable iff (rst)
    sync_irq |-> $past(acc && op == OP_SYNC)); // R10

  AST_HALT_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
    halted |-> !cmd_ready); // R12

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(err_code)); // R12

  AST_SILENT_WHEN_HALTED: assert property (@(posedge clk) disable iff (rst)
    halted && $past(halted) |-> !any_strobe); // R12

endmodule

bind inv_cmd_decoder inv_cmd_decoder_chk #(
  .SID_W   (SID_W),
  .ASID_W  (ASID_W),
  .ADDR_W  (ADDR_W),
  .RANGE_W (RANGE_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cmd_valid       (cmd_valid),
  .cmd_ready       (cmd_ready),
  .cmd_word        (cmd_word),
  .stream_attached (stream_attached),
  .cfg_flush       (cfg_flush),
  .tlb_inv_all     (tlb_inv_all),
  .tlb_inv_asid    (tlb_inv_asid),
  .tlb_inv_va      (tlb_inv_va),
  .sync_irq        (sync_irq),
  .err_code        (err_code),
  .halted          (halted)
);

// File: tb/inv_cmd_decoder_test.sv
module inv_cmd_decoder_test;

  localparam int SID_W   = 8;
  localparam int ASID_W  = 16;
  localparam int ADDR_W  = 32;
  localparam int RANGE_W = 5;
  localparam int NS      = 1 << SID_W;
  localparam int CMD_W   = 11 + RANGE_W + SID_W + ASID_W + ADDR_W;
  localparam int NVEC    = 16;

  // entry: op[75:68] sec[67] mode[66:65] range[64:60] sid[59:52] asid[51:36] addr[35:4]
  //        expected {all, asid, va, irq}[3:0]
  localparam logic [75:0] VEC [NVEC] = '{
    {8'h01, 1'b0, 2'd0, 5'd0, 8'd0,   16'h0000, 32'h0,        4'b0000}, // R9
    {8'h02, 1'b0, 2'd0, 5'd0, 8'd7,   16'h0000, 32'h1000,     4'b0000}, // R9
    {8'h03, 1'b0, 2'd0, 5'd0, 8'd5,   16'h0000, 32'h0,        4'b0000}, // R2 attached
    {8'h03, 1'b0, 2'd0, 5'd0, 8'd6,   16'h0000, 32'h0,        4'b0000}, // R2 detached
    {8'h05, 1'b0, 2'd0, 5'd0, 8'd10,  16'h0000, 32'h0,        4'b0000}, // R2
    {8'h06, 1'b0, 2'd0, 5'd0, 8'd11,  16'h0000, 32'h0,        4'b0000}, // R2
    {8'h04, 1'b0, 2'd0, 5'd1, 8'd8,   16'h0000, 32'h0,        4'b0000}, // R3 8..11
    {8'h04, 1'b0, 2'd0, 5'd3, 8'd250, 16'h0000, 32'h0,        4'b0000}, // R3 clipped
    {8'h10, 1'b0, 2'd0, 5'd0, 8'd0,   16'h0000, 32'h0,        4'b1000}, // R5
    {8'h30, 1'b0, 2'd0, 5'd0, 8'd0,   16'h0000, 32'h0,        4'b1000}, // R5
    {8'h11, 1'b0, 2'd0, 5'd0, 8'd0,   16'h1234, 32'h0,        4'b0100}, // R6
    {8'h12, 1'b0, 2'd0, 5'd0, 8'd0,   16'h0055, 32'hdeadb000, 4'b0010}, // R8
    {8'h13, 1'b0, 2'd0, 5'd0, 8'd0,   16'h0077, 32'h00400000, 4'b1000}, // R7
    {8'h46, 1'b0, 2'd1, 5'd0, 8'd0,   16'h0000, 32'h0,        4'b0001}, // R10
    {8'h46, 1'b0, 2'd0, 5'd0, 8'd0,   16'h0000, 32'h0,        4'b0000}, // R10
    {8'h11, 1'b1, 2'd0, 5'd0, 8'd0,   16'h00ab, 32'h0,        4'b0100}  // R13
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [CMD_W-1:0]  cmd_word = '0;
  logic [NS-1:0]     stream_attached;
  logic [NS-1:0]     cfg_flush;
  logic              tlb_inv_all, tlb_inv_asid, tlb_inv_va, sync_irq, halted;
  logic [ASID_W-1:0] tlb_asid;
  logic [ADDR_W-1:0] tlb_addr;
  logic [1:0]        err_code;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  inv_cmd_decoder #(
    .SID_W(SID_W), .ASID_W(ASID_W), .ADDR_W(ADDR_W), .RANGE_W(RANGE_W)
  ) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .stream_attached(stream_attached), .cfg_flush(cfg_flush),
    .tlb_inv_all(tlb_inv_all), .tlb_inv_asid(tlb_inv_asid), .tlb_inv_va(tlb_inv_va),
    .tlb_asid(tlb_asid), .tlb_addr(tlb_addr), .sync_irq(sync_irq),
    .err_code(err_code), .halted(halted)
  );

  task automatic check(input bit ok, input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CMD_W-1:0] mk(input logic [7:0] op, input logic sec, input logic [1:0] mode,
                                          input logic [4:0] rng, input logic [7:0] sid,
                                          input logic [15:0] asid, input logic [31:0] addr);
    return {addr, asid, sid, rng, mode, sec, op};
  endfunction

  function automatic logic [NS-1:0] model_mask(input logic [7:0] op, input logic sec,
                                               input logic [4:0] rng, input logic [7:0] sid);
    logic [NS-1:0] m = '0;
    longint hi;
    if (!sec && (op == 8'h03 || op == 8'h05 || op == 8'h06)) m[sid] = stream_attached[sid];
    if (!sec && op == 8'h04) begin
      hi = longint'(sid) + (longint'(1) << (rng + 1)) - 1;
      for (int i = 0; i < NS; i++)
        if (i >= sid && longint'(i) <= hi) m[i] = stream_attached[i];
    end
    return m;
  endfunction

  function automatic string req_of(input logic [7:0] op, input logic sec);
    if (sec && !(op >= 8'h03 && op <= 8'h06)) return "R13";
    case (op)
      8'h01, 8'h02: return "R9";
      8'h03, 8'h05, 8'h06: return "R2";
      8'h04: return "R3";
      8'h10, 8'h30: return "R5";
      8'h11: return "R6";
      8'h12: return "R8";
      8'h13: return "R7";
      8'h46: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic send(input logic [CMD_W-1:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_halt_blocks(input string req);
    logic seen = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = mk(8'h10, 0, 0, 0, 0, 0, 0);
    repeat (3) begin
      @(negedge clk);
      seen = seen | tlb_inv_all | cmd_ready;
    end
    cmd_valid = 1'b0;
    check(!seen && halted && err_code == 2'd1, req, NS'({seen, halted, err_code}), NS'({1'b0, 1'b1, 2'd1}));
  endtask

  initial begin
    for (int i = 0; i < NS; i++) stream_attached[i] = (i % 3) != 0;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check(cmd_ready && !halted && err_code == 0 && cfg_flush == 0 &&
          !tlb_inv_all && !tlb_inv_asid && !tlb_inv_va && !sync_irq,
          "R1 reset", NS'({cmd_ready, halted, err_code}), NS'({1'b1, 1'b0, 2'd0}));

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0]    op   = VEC[v][75:68];
      logic          sec  = VEC[v][67];
      logic [4:0]    rng  = VEC[v][64:60];
      logic [7:0]    sid  = VEC[v][59:52];
      logic [15:0]   asid = VEC[v][51:36];
      logic [31:0]   addr = VEC[v][35:4];
      logic [3:0]    ef   = VEC[v][3:0];
      logic [NS-1:0] em   = model_mask(op, sec, rng, sid);
      string         rq   = req_of(op, sec);
      send(mk(op, sec, VEC[v][66:65], rng, sid, asid, addr));
      check(cfg_flush == em, rq, cfg_flush, em);
      check({tlb_inv_all, tlb_inv_asid, tlb_inv_va, sync_irq} == ef, rq,
            NS'({tlb_inv_all, tlb_inv_asid, tlb_inv_va, sync_irq}), NS'(ef));
      if (ef[2] || ef[1]) check(tlb_asid == asid, rq, NS'(tlb_asid), NS'(asid));
      if (ef[1]) check(tlb_addr == addr, rq, NS'(tlb_addr), NS'(addr));
      check(err_code == 0 && cmd_ready, rq, NS'({err_code, cmd_ready}), NS'({2'd0, 1'b1}));
      @(negedge clk);
      // R1 pulses last a single cycle
      check(cfg_flush == 0 && !tlb_inv_all && !tlb_inv_asid && !tlb_inv_va && !sync_irq,
            "R1 pulse", NS'({tlb_inv_all, tlb_inv_asid, tlb_inv_va, sync_irq}), '0);
    end

    // R3 widest range covers every attached stream
    send(mk(8'h04, 0, 0, 5'd31, 8'd0, 0, 0));
    check(cfg_flush == stream_attached, "R3 full span", cfg_flush, stream_attached);

    // R4 secure config command rejected, R12 halts
    send(mk(8'h03, 1, 0, 0, 8'd5, 0, 0));
    check(cfg_flush == 0 && err_code == 2'd1, "R4 secure", NS'({err_code, |cfg_flush}), NS'({2'd1, 1'b0}));
    check_halt_blocks("R12 halt");

    do_reset();
    send(mk(8'h04, 1, 0, 5'd2, 8'd1, 0, 0));
    check(cfg_flush == 0 && err_code == 2'd1, "R4 secure range", NS'({err_code, |cfg_flush}), NS'({2'd1, 1'b0}));

    // R11 unknown opcode
    do_reset();
    send(mk(8'h7f, 0, 0, 0, 0, 0, 0));
    check(err_code == 2'd1 && halted, "R11 unknown", NS'({err_code, halted}), NS'({2'd1, 1'b1}));
    check_halt_blocks("R12 after unknown");

    do_reset();
    @(negedge clk);
    check(cmd_ready && err_code == 0, "R1 reset clears error", NS'({cmd_ready, err_code}), NS'({1'b1, 2'd0}));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule